// File: doc/BRIEF.md
# Element-Addressed Vector Register File

This block stores a bank of 32 equally sized vector registers and lets a datapath reach them one element at a time. An element is named by a base register number, an element index, a 3-bit element-width code and a 3-bit register-group code. The group code sets how many bytes the element index may span. It can be a whole multiple of one register or a fraction of one. Before any byte is touched, each access is checked against two limits: the span of the register group and the end of the file. The block reports the outcome on a per-port legality flag.

There is one combinational element read port and one element write port that commits on the clock edge. A third port looks up a single mask bit for an element index in a chosen mask register. A standalone decoder turns a group code into its factor scaled by eight, for use by neighbouring logic. A synchronous active-low reset or a clear strobe zeroes the whole store.

Top module: `vrf_elem_file`

## Requirements
- R1: While `rst_n` is low, or when `clr` is high, every byte of the store becomes zero at the rising edge. `clr` takes priority over a write in the same cycle.
- R2: `lm_x8` decodes `lm_code` as 0→8, 1→16, 2→32, 3→64, 5→1, 6→2, 7→4. Code 4 is reserved and gives 0.
- R3: An element holds 1<<ew bytes, where ew is the width code. Width codes above 3 (elements wider than the 64-bit data ports) are rejected.
- R4: An access is rejected when (index+1)×element bytes×8 exceeds 8 bytes-per-register×the decoded group factor. Group code 4 is therefore always rejected.
- R5: An access is rejected when register×8 + (index+1)×element bytes exceeds 256. An element may lie in a register that follows its base register.
- R6: Elements are little-endian. Element i of width w occupies bytes base×8 + i×w upward. Read data carries the element in its low bytes, and all bytes above the element width are zero.
- R7: A rejected read drives `rd_ok` low and `rd_data` zero in the same cycle.
- R8: `wr_ok` shows whether the write access is legal. A rejected or disabled write leaves every stored byte unchanged.
- R9: Writes take effect at the rising edge. A read in the same cycle as a write to the same bytes returns the old data.
- R10: `mk_active` is bit (index & 7) of byte (index >> 3) of mask register `mk_reg`.
- R11: `mk_active` is 0 when `mk_reg` is 32 or more, or when index >> 3 is 8 or more.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset, clears the store |
| clr | input | 1 | Clear strobe (reconfiguration), zeroes the store |
| wr_en | input | 1 | Write request |
| wr_reg | input | 5 | Write base register |
| wr_idx | input | 8 | Write element index |
| wr_ew | input | 3 | Write element-width code |
| wr_lmul | input | 3 | Write group code |
| wr_data | input | 64 | Write element, low bytes used |
| wr_ok | output | 1 | Write access is legal |
| rd_reg | input | 5 | Read base register |
| rd_idx | input | 8 | Read element index |
| rd_ew | input | 3 | Read element-width code |
| rd_lmul | input | 3 | Read group code |
| rd_data | output | 64 | Read element, zero-extended |
| rd_ok | output | 1 | Read access is legal |
| mk_reg | input | 6 | Mask register number |
| mk_idx | input | 8 | Mask element index |
| mk_active | output | 1 | Mask bit for that element |
| lm_code | input | 3 | Group code to decode |
| lm_x8 | output | 7 | Group factor scaled by eight |

## Verification
The read port and the write port can be active in the same cycle, and they may overlap the same bytes. Random traffic does this often, and directed steps add it on purpose: a write and a read of the same element are issued together. The read is judged against the bench's byte model as it stood before that edge. A later read then checks that the new value landed. The clear strobe is also raised together with a legal write, and the bytes must read back as zero.

// File: rtl/vrf_pkg.sv
// Shared types for the element-addressed vector register file.
// Assumes 3-bit group and width codes.
package vrf_pkg;
    typedef enum logic [2:0] {
        GRP_X1     = 3'd0,
        GRP_X2     = 3'd1,
        GRP_X4     = 3'd2,
        GRP_X8     = 3'd3,
        GRP_RSV    = 3'd4,
        GRP_EIGHTH = 3'd5,
        GRP_QUART  = 3'd6,
        GRP_HALF   = 3'd7
    } grp_code_e;

    localparam int GRP_X8_W = 7;
endpackage

// File: rtl/vrf_lmul_dec.sv
// Group-code decoder: turns a 3-bit group code into its factor scaled
// by eight. The reserved code yields zero. Purely combinational.
module vrf_lmul_dec
    import vrf_pkg::*;
(
    input  logic [2:0]          code,
    output logic [GRP_X8_W-1:0] x8
);
    // Table decode of the scaled group factor
    always_comb begin
        unique case (grp_code_e'(code))
            GRP_X1:     x8 = 7'd8;
            GRP_X2:     x8 = 7'd16;
            GRP_X4:     x8 = 7'd32;
            GRP_X8:     x8 = 7'd64;
            GRP_EIGHTH: x8 = 7'd1;
            GRP_QUART:  x8 = 7'd2;
            GRP_HALF:   x8 = 7'd4;
            default:    x8 = 7'd0;
        endcase
    end
endmodule

// File: rtl/vrf_bound_chk.sv
// Access legality and address generation for one element port.
// It checks the width-code range, the register-group span and the end
// of the file. It also returns the starting byte offset and the element
// size. The offset is meaningful only while ok is high.
module vrf_bound_chk
    import vrf_pkg::*;
#(
    parameter int NUM_REGS    = 32,
    parameter int REG_BYTES   = 8,
    parameter int EW_MAX_CODE = 3,
    parameter int IDX_W       = 8,
    localparam int REG_W       = $clog2(NUM_REGS),
    localparam int TOTAL_BYTES = NUM_REGS * REG_BYTES,
    localparam int ADDR_W      = $clog2(TOTAL_BYTES),
    localparam int EB_MAX      = 1 << EW_MAX_CODE,
    localparam int EBW         = $clog2(EB_MAX) + 1
) (
    input  logic [REG_W-1:0]  regn,
    input  logic [IDX_W-1:0]  idx,
    input  logic [2:0]        ew,
    input  logic [2:0]        lmul,
    output logic              ok,
    output logic [ADDR_W-1:0] base,
    output logic [EBW-1:0]    ebytes
);
    logic [GRP_X8_W-1:0] x8;
    int unsigned eb_i, span, grp_lim, end_off;
    logic ew_ok, grp_ok, file_ok;

    vrf_lmul_dec u_dec (.code(lmul), .x8(x8));

    // Evaluate both limits and the byte offset of the element
    always_comb begin
        eb_i    = 32'd1 << ew;
        span    = (32'(idx) + 32'd1) * eb_i;
        grp_lim = 32'(REG_BYTES) * 32'(x8);
        end_off = 32'(regn) * 32'(REG_BYTES) + span;
        ew_ok   = (32'(ew) <= 32'(EW_MAX_CODE));
        grp_ok  = (x8 != '0) && (span * 32'd8 <= grp_lim);
        file_ok = (end_off <= 32'(TOTAL_BYTES));
        ok      = ew_ok && grp_ok && file_ok;
        base    = ADDR_W'(32'(regn) * 32'(REG_BYTES) + 32'(idx) * eb_i);
        ebytes  = EBW'(eb_i);
    end
endmodule

// File: rtl/vrf_elem_file.sv
// Element-addressed vector register file, top level.
// It holds NUM_REGS registers of REG_BYTES bytes as a flat little-endian
// byte store. It has one combinational read port, one edge-committed
// write port, a mask-bit lookup and a standalone group-code decoder.
// Assumes a single clock and a synchronous active-low reset.
module vrf_elem_file
    import vrf_pkg::*;
#(
    parameter int NUM_REGS    = 32,
    parameter int REG_BYTES   = 8,
    parameter int EW_MAX_CODE = 3,
    parameter int IDX_W       = 8,
    parameter int MIDX_W      = 8,
    localparam int REG_W       = $clog2(NUM_REGS),
    localparam int TOTAL_BYTES = NUM_REGS * REG_BYTES,
    localparam int ADDR_W      = $clog2(TOTAL_BYTES),
    localparam int EB_MAX      = 1 << EW_MAX_CODE,
    localparam int EBW         = $clog2(EB_MAX) + 1,
    localparam int DATA_W      = 8 * EB_MAX
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr,
    input  logic                wr_en,
    input  logic [REG_W-1:0]    wr_reg,
    input  logic [IDX_W-1:0]    wr_idx,
    input  logic [2:0]          wr_ew,
    input  logic [2:0]          wr_lmul,
    input  logic [DATA_W-1:0]   wr_data,
    output logic                wr_ok,
    input  logic [REG_W-1:0]    rd_reg,
    input  logic [IDX_W-1:0]    rd_idx,
    input  logic [2:0]          rd_ew,
    input  logic [2:0]          rd_lmul,
    output logic [DATA_W-1:0]   rd_data,
    output logic                rd_ok,
    input  logic [REG_W:0]      mk_reg,
    input  logic [MIDX_W-1:0]   mk_idx,
    output logic                mk_active,
    input  logic [2:0]          lm_code,
    output logic [GRP_X8_W-1:0] lm_x8
);
    logic [7:0]        store [TOTAL_BYTES];
    logic [ADDR_W-1:0] wr_base, rd_base;
    logic [EBW-1:0]    wr_eb, rd_eb;

    vrf_bound_chk #(
        .NUM_REGS(NUM_REGS), .REG_BYTES(REG_BYTES),
        .EW_MAX_CODE(EW_MAX_CODE), .IDX_W(IDX_W)
    ) u_wchk (
        .regn(wr_reg), .idx(wr_idx), .ew(wr_ew), .lmul(wr_lmul),
        .ok(wr_ok), .base(wr_base), .ebytes(wr_eb)
    );

    vrf_bound_chk #(
        .NUM_REGS(NUM_REGS), .REG_BYTES(REG_BYTES),
        .EW_MAX_CODE(EW_MAX_CODE), .IDX_W(IDX_W)
    ) u_rchk (
        .regn(rd_reg), .idx(rd_idx), .ew(rd_ew), .lmul(rd_lmul),
        .ok(rd_ok), .base(rd_base), .ebytes(rd_eb)
    );

    vrf_lmul_dec u_ldec (.code(lm_code), .x8(lm_x8));

    // Byte store: clear on reset or clr, else commit a legal write
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            for (int b = 0; b < TOTAL_BYTES; b++) store[b] <= 8'h00;
        end else if (wr_en && wr_ok) begin
            for (int k = 0; k < EB_MAX; k++) begin
                if (k < int'(wr_eb))
                    store[ADDR_W'(int'(wr_base) + k)] <= wr_data[8*k +: 8];
            end
        end
    end

    // Combinational element read, zero when illegal or above the width
    always_comb begin
        rd_data = '0;
        for (int k = 0; k < EB_MAX; k++) begin
            if (rd_ok && k < int'(rd_eb))
                rd_data[8*k +: 8] = store[ADDR_W'(int'(rd_base) + k)];
        end
    end

    // Mask-bit lookup with range guards on register and byte
    always_comb begin
        int unsigned mbyte;
        mbyte     = 32'(mk_idx) >> 3;
        mk_active = 1'b0;
        if (32'(mk_reg) < 32'(NUM_REGS) && mbyte < 32'(REG_BYTES))
            mk_active = store[ADDR_W'(32'(mk_reg) * 32'(REG_BYTES) + mbyte)][mk_idx[2:0]];
    end
endmodule

// File: rtl/vrf_elem_file_chk.sv
// Property checker for vrf_elem_file, attached by bind below.
module vrf_elem_file_chk #(
    parameter int NUM_REGS    = 32,
    parameter int EW_MAX_CODE = 3,
    parameter int REG_W       = 5,
    parameter int DATA_W      = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              clr,
    input logic              wr_ok,
    input logic [2:0]        wr_ew,
    input logic [2:0]        rd_ew,
    input logic [2:0]        rd_lmul,
    input logic              rd_ok,
    input logic [DATA_W-1:0] rd_data,
    input logic [REG_W:0]    mk_reg,
    input logic              mk_active,
    input logic [2:0]        lm_code,
    input logic [6:0]        lm_x8
);
    logic just_cleared;

    // Remember that the previous edge cleared the store
    always_ff @(posedge clk) just_cleared <= !rst_n || clr;

    // R1
    cleared_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        just_cleared |-> rd_data == '0);
    // R2
    rsv_decode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lm_code == 3'd4 |-> lm_x8 == 7'd0);
    // R2
    pow2_decode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lm_code != 3'd4 |-> $countones(lm_x8) == 1);
    // R3
    wide_rd_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        32'(rd_ew) > 32'(EW_MAX_CODE) |-> !rd_ok);
    // R3
    wide_wr_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        32'(wr_ew) > 32'(EW_MAX_CODE) |-> !wr_ok);
    // R4
    rsv_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_lmul == 3'd4 |-> !rd_ok);
    // R6
    byte_elem_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ew == 3'd0 |-> rd_data[DATA_W-1:8] == '0);
    // R7
    reject_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_ok |-> rd_data == '0);
    // R11
    mask_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        32'(mk_reg) >= 32'(NUM_REGS) |-> !mk_active);
endmodule

bind vrf_elem_file vrf_elem_file_chk #(
    .NUM_REGS(NUM_REGS), .EW_MAX_CODE(EW_MAX_CODE),
    .REG_W(REG_W), .DATA_W(DATA_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .clr(clr), .wr_ok(wr_ok), .wr_ew(wr_ew),
    .rd_ew(rd_ew), .rd_lmul(rd_lmul), .rd_ok(rd_ok), .rd_data(rd_data),
    .mk_reg(mk_reg), .mk_active(mk_active), .lm_code(lm_code), .lm_x8(lm_x8)
);

// File: tb/vrf_elem_file_test.sv
// Bench for vrf_elem_file: seeded random traffic plus directed corners,
// compared against a byte-level model kept in the bench.
module vrf_elem_file_test;
    localparam int NR = 32;
    localparam int RB = 8;
    localparam int TB = NR * RB;

    logic        clk = 1'b0;
    logic        rst_n, clr, wr_en;
    logic [4:0]  wr_reg, rd_reg;
    logic [7:0]  wr_idx, rd_idx, mk_idx;
    logic [2:0]  wr_ew, wr_lmul, rd_ew, rd_lmul, lm_code;
    logic [63:0] wr_data, rd_data;
    logic        wr_ok, rd_ok, mk_active;
    logic [5:0]  mk_reg;
    logic [6:0]  lm_x8;

    logic [7:0]  model [TB];
    int total = 0;
    int bad = 0;

    always #5 clk = ~clk;

    vrf_elem_file uut (
        .clk(clk), .rst_n(rst_n), .clr(clr), .wr_en(wr_en), .wr_reg(wr_reg),
        .wr_idx(wr_idx), .wr_ew(wr_ew), .wr_lmul(wr_lmul), .wr_data(wr_data),
        .wr_ok(wr_ok), .rd_reg(rd_reg), .rd_idx(rd_idx), .rd_ew(rd_ew),
        .rd_lmul(rd_lmul), .rd_data(rd_data), .rd_ok(rd_ok), .mk_reg(mk_reg),
        .mk_idx(mk_idx), .mk_active(mk_active), .lm_code(lm_code), .lm_x8(lm_x8)
    );

    function automatic int exp_x8(input int c);
        case (c)
            0: return 8;  1: return 16; 2: return 32; 3: return 64;
            5: return 1;  6: return 2;  7: return 4;
            default: return 0;
        endcase
    endfunction

    function automatic bit exp_ok(input int r, input int i, input int ew, input int lm);
        int eb;
        if (ew > 3) return 1'b0;
        eb = 1 << ew;
        if ((i + 1) * eb * 8 > RB * exp_x8(lm)) return 1'b0;
        if (r * RB + (i + 1) * eb > TB) return 1'b0;
        return 1'b1;
    endfunction

    function automatic logic [63:0] exp_rd(input int r, input int i, input int ew, input int lm);
        logic [63:0] v = '0;
        int eb;
        if (!exp_ok(r, i, ew, lm)) return '0;
        eb = 1 << ew;
        for (int k = 0; k < eb; k++) v[8*k +: 8] = model[r * RB + i * eb + k];
        return v;
    endfunction

    function automatic bit exp_mask(input int mr, input int mi);
        if (mr >= NR || (mi >> 3) >= RB) return 1'b0;
        return model[mr * RB + (mi >> 3)][mi & 7];
    endfunction

    task automatic chk(input bit good, input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!good) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Check all combinational outputs, then let one edge pass and update the model
    task automatic step(input string tag);
        logic [63:0] e;
        #1;
        e = 64'(exp_ok(wr_reg, wr_idx, wr_ew, wr_lmul));
        chk(wr_ok == e[0], {tag, " R8 wr_ok"}, 64'(wr_ok), e);
        e = 64'(exp_ok(rd_reg, rd_idx, rd_ew, rd_lmul));
        chk(rd_ok == e[0], {tag, " R4/R5 rd_ok"}, 64'(rd_ok), e);
        e = exp_rd(rd_reg, rd_idx, rd_ew, rd_lmul);
        chk(rd_data == e, {tag, " R6 R7 R9 rd_data"}, rd_data, e);
        e = 64'(exp_mask(mk_reg, mk_idx));
        chk(mk_active == e[0], {tag, " R10 R11 mask"}, 64'(mk_active), e);
        e = 64'(exp_x8(lm_code));
        chk(64'(lm_x8) == e, {tag, " R2 decode"}, 64'(lm_x8), e);
        @(posedge clk);
        if (!rst_n || clr) begin
            for (int b = 0; b < TB; b++) model[b] = 8'h00;
        end else if (wr_en && exp_ok(wr_reg, wr_idx, wr_ew, wr_lmul)) begin
            for (int k = 0; k < (1 << wr_ew); k++)
                model[wr_reg * RB + wr_idx * (1 << wr_ew) + k] = wr_data[8*k +: 8];
        end
        @(negedge clk);
    endtask

    task automatic set_wr(input bit en, input int r, input int i, input int ew, input int lm, input logic [63:0] d);
        wr_en = en; wr_reg = 5'(r); wr_idx = 8'(i); wr_ew = 3'(ew); wr_lmul = 3'(lm); wr_data = d;
    endtask

    task automatic set_rd(input int r, input int i, input int ew, input int lm);
        rd_reg = 5'(r); rd_idx = 8'(i); rd_ew = 3'(ew); rd_lmul = 3'(lm);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        for (int b = 0; b < TB; b++) model[b] = 8'h00;
        rst_n = 1'b0; clr = 1'b0; mk_reg = '0; mk_idx = '0; lm_code = '0;
        set_wr(1'b0, 0, 0, 0, 0, '0);
        set_rd(0, 0, 0, 0);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state reads as zero
        set_rd(3, 0, 3, 0);
        step("R1 reset");
        // R2: every group code
        for (int c = 0; c < 8; c++) begin
            lm_code = 3'(c);
            step("R2 table");
        end
        // R6: little-endian fill of reg 2 by bytes, then read as one doubleword
        for (int i = 0; i < 8; i++) begin
            set_wr(1'b1, 2, i, 0, 0, 64'(8'h10 + i));
            step("R6 bytes");
        end
        set_wr(1'b0, 0, 0, 0, 0, '0);
        set_rd(2, 0, 3, 0);
        step("R6 word");
        // R5: last register, element past end rejected
        set_wr(1'b1, 31, 0, 3, 0, 64'hA5A5_0000_1111_2222);
        step("R5 last");
        set_wr(1'b1, 31, 1, 3, 1, 64'hDEAD_BEEF_DEAD_BEEF);
        set_rd(31, 1, 3, 1);
        step("R5 R8 beyond end");
        set_wr(1'b0, 0, 0, 0, 0, '0);
        set_rd(31, 0, 3, 0);
        step("R8 unchanged");
        // R5: element in the register after the base
        set_wr(1'b1, 30, 1, 3, 1, 64'h0123_4567_89AB_CDEF);
        step("R5 spill");
        set_wr(1'b0, 0, 0, 0, 0, '0);
        set_rd(31, 0, 3, 0);
        step("R5 spill read");
        // R4: fractional groups and reserved code
        set_rd(2, 0, 0, 5); step("R4 eighth ok");
        set_rd(2, 1, 0, 5); step("R4 eighth reject");
        set_rd(2, 1, 0, 6); step("R4 quarter ok");
        set_rd(2, 0, 2, 7); step("R4 half ok");
        set_rd(2, 0, 3, 7); step("R4 half reject");
        set_rd(2, 0, 0, 4); step("R4 reserved");
        set_rd(2, 0, 4, 3); step("R3 wide code");
        // R9: read and write same element in one cycle
        set_wr(1'b1, 2, 0, 3, 0, 64'hFACE_FACE_FACE_FACE);
        set_rd(2, 0, 3, 0);
        step("R9 same cycle");
        set_wr(1'b0, 0, 0, 0, 0, '0);
        step("R9 after edge");
        // R10 R11: mask lookups
        mk_reg = 6'd2; mk_idx = 8'd5;  step("R10 mask");
        mk_reg = 6'd2; mk_idx = 8'd70; step("R11 byte range");
        mk_reg = 6'd33; mk_idx = 8'd0; step("R11 reg range");
        // R1: clear beats write
        clr = 1'b1;
        set_wr(1'b1, 2, 0, 3, 0, 64'hFFFF_FFFF_FFFF_FFFF);
        step("R1 clear");
        clr = 1'b0;
        set_wr(1'b0, 0, 0, 0, 0, '0);
        set_rd(2, 0, 3, 0);
        step("R1 cleared");
        // Random traffic
        for (int n = 0; n < 3000; n++) begin
            set_wr(($urandom % 4) != 0, $urandom % 32, $urandom % 20,
                   $urandom % 5, $urandom % 8, {$urandom, $urandom});
            set_rd($urandom % 32, $urandom % 20, $urandom % 5, $urandom % 8);
            mk_reg  = 6'($urandom % 34);
            mk_idx  = 8'($urandom % 80);
            lm_code = 3'($urandom % 8);
            clr     = ($urandom % 500) == 0;
            step("random");
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule